// File: doc/BRIEF.md
# History-Addressed Binary Trie Lookup Engine

This engine finds the longest matching prefix of a destination key in a binary trie whose nodes hold no child addresses. The address of every node is worked out on the fly from the path that leads to it. A running register holds the key bits consumed so far. Together with the current depth and a short discriminator field kept in the parent node, this register forms an identifier. A combinational folding circuit reduces the identifier modulo the table size to give the address in a synchronous node table.

A lookup starts with a one-cycle start pulse that carries a key and its length. The key is consumed MSB-first: a 0 moves the walk to the left child and a 1 moves it to the right child. Each node costs one fetch cycle and one evaluate cycle. The engine remembers the deepest node whose prefix flag is set. When the walk ends, it raises a one-cycle done pulse with a hit flag, the table address of that node and its depth. A separate slower memory then uses the address once to fetch the next hop.

A host write port fills the table. How the table contents are built is decided outside the block.

Top module: `hx_trie_lookup`

## Requirements
- R1: While reset is active and after it is released, busy, done and hit read 0, and match_addr and match_depth read 0, until the first lookup completes.
- R2: A node word is {prefix flag at bit 2*DISC_W, left-child discriminator at bits [2*DISC_W-1:DISC_W], right-child discriminator at bits [DISC_W-1:0]}. A discriminator of 0 means the child does not exist.
- R3: The node at depth d has history h and discriminator c. Bit 0 of h is the most recently consumed key bit, and h is zero-extended to KEY_W bits. The node's table address is the value {h, d as LEN_W bits, c as DISC_W bits} modulo TBL_DEPTH. The root has h=0, d=0 and c=ROOT_DISC.
- R4: The key is consumed MSB-first, so key bit KEY_W-1-d chooses the step taken from depth d. A 0 selects the left child and a 1 selects the right child.
- R5: Of the nodes visited, the deepest one with its prefix flag set is reported. The engine then sets hit=1, match_addr to that node's table address and match_depth to that node's depth.
- R6: The walk ends at a node in either of two cases: its depth equals key_len, or the discriminator of the selected child is 0.
- R7: When no visited node has its prefix flag set, done comes with hit=0, match_addr=0 and match_depth=0.
- R8: Suppose start is sampled at clock edge E and the walk visits N nodes. Then busy is high from E until done rises, and done is high for exactly one cycle, after edge E+2N.
- R9: A start pulse that arrives while busy is high is ignored, and the walk in progress finishes with its own result.
- R10: Host table writes made while busy is high are dropped. Writes made while busy is low take effect.
- R11: After done, hit, match_addr and match_depth hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a lookup |
| key | input | KEY_W | Destination key, left-aligned, consumed MSB-first |
| key_len | input | LEN_W | Number of key bits to consume (values above KEY_W are treated as KEY_W) |
| wr_en | input | 1 | Host table write strobe |
| wr_addr | input | ADDR_W | Host write table address |
| wr_data | input | WORD_W | Host write node word |
| busy | output | 1 | A lookup is in progress |
| done | output | 1 | One-cycle pulse at the end of a lookup |
| hit | output | 1 | At least one visited node carried a prefix flag |
| match_addr | output | ADDR_W | Table address of the longest matching node |
| match_depth | output | LEN_W | Depth, in bits, of the longest matching node |

## Verification
The bench places a nine-node trie using its own modulo hash and varies the discriminator chosen per node, so that a wrong address formula or a swapped field sends the walk to an empty slot. The keys are chosen to end the walk in different ways. Some end on a leaf, some on a missing left or right child, and some on key exhaustion at a node that still has children. Some hit several prefix nodes on one path, which shows whether the deepest or the first is kept, and some find no prefix at all. Making the root a prefix separates a depth-0 hit from a miss. The bench also issues starts and writes while a walk is in flight, which shows whether these are ignored or whether they restart or corrupt the walk. A cycle count for each walk checks the two-cycle-per-node latency.

// File: rtl/hx_pkg.sv
package hx_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_FETCH = 2'd1,
    WALK_EVAL  = 2'd2
  } walk_state_e;

  // Weight of identifier bit position bit_pos in the residue sum: 2^bit_pos mod modulus.
  function automatic int pow2_mod(input int bit_pos, input int modulus);
    int r;
    r = 1 % modulus;
    for (int k = 0; k < bit_pos; k++) begin
      r = (r * 2) % modulus;
    end
    return r;
  endfunction

endpackage

// File: rtl/hx_addr_hash.sv
module hx_addr_hash #(
  parameter int KEY_W     = 32,
  parameter int LEN_W     = 6,
  parameter int DISC_W    = 2,
  parameter int TBL_DEPTH = 61,
  parameter int ADDR_W    = 6
) (
  input  logic [KEY_W-1:0]  hist,
  input  logic [LEN_W-1:0]  depth,
  input  logic [DISC_W-1:0] disc,
  output logic [ADDR_W-1:0] addr
);

  localparam int ID_W  = KEY_W + LEN_W + DISC_W;
  localparam int SUM_W = ADDR_W + $clog2(ID_W + 1);

  logic [ID_W-1:0]   ident;
  logic [ADDR_W-1:0] terms [ID_W];
  logic [SUM_W-1:0]  resid_sum;

  assign ident = {hist, depth, disc};

  // Each set identifier bit contributes its constant residue.
  for (genvar g = 0; g < ID_W; g++) begin : g_term
    localparam logic [ADDR_W-1:0] WEIGHT = ADDR_W'(hx_pkg::pow2_mod(g, TBL_DEPTH));
    assign terms[g] = ident[g] ? WEIGHT : '0;
  end

  always_comb begin
    resid_sum = '0;
    for (int i = 0; i < ID_W; i++) begin
      resid_sum = resid_sum + SUM_W'(terms[i]);
    end
  end

  // Final reduction of the short residue sum.
  assign addr = ADDR_W'(resid_sum % SUM_W'(TBL_DEPTH));

endmodule

// File: rtl/hx_node_table.sv
module hx_node_table #(
  parameter int DEPTH  = 61,
  parameter int ADDR_W = 6,
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;
  logic              wr_in_range;

  assign wr_in_range = (int'(wr_addr) < DEPTH);

  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= mem[rd_addr];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/hx_walk_ctrl.sv
module hx_walk_ctrl
  import hx_pkg::*;
#(
  parameter int KEY_W     = 32,
  parameter int LEN_W     = 6,
  parameter int DISC_W    = 2,
  parameter int ADDR_W    = 6,
  parameter int ROOT_DISC = 1,
  localparam int WORD_W   = 1 + 2 * DISC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KEY_W-1:0]  key,
  input  logic [LEN_W-1:0]  key_len,
  input  logic [WORD_W-1:0] node_word,
  input  logic [ADDR_W-1:0] node_addr,
  output logic [KEY_W-1:0]  hist,
  output logic [LEN_W-1:0]  depth,
  output logic [DISC_W-1:0] cur_disc,
  output logic              rd_en,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [ADDR_W-1:0] match_addr,
  output logic [LEN_W-1:0]  match_depth
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(KEY_W);

  walk_state_e       state_q, state_d;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [LEN_W-1:0]  lim_q, lim_d;
  logic [KEY_W-1:0]  hist_q, hist_d;
  logic [LEN_W-1:0]  depth_q, depth_d;
  logic [DISC_W-1:0] disc_q, disc_d;
  logic              done_q, done_d;
  logic              hit_q, hit_d;
  logic [ADDR_W-1:0] maddr_q, maddr_d;
  logic [LEN_W-1:0]  mdepth_q, mdepth_d;

  logic              walk_en;
  logic              res_en;
  logic              node_pfx;
  logic [DISC_W-1:0] left_disc, right_disc, child_disc;
  logic              step_bit;

  assign node_pfx   = node_word[2*DISC_W];
  assign left_disc  = node_word[2*DISC_W-1:DISC_W];
  assign right_disc = node_word[DISC_W-1:0];
  assign step_bit   = key_q[KEY_W-1];
  assign child_disc = step_bit ? right_disc : left_disc;

  // Next-state process
  always_comb begin
    state_d  = state_q;
    key_d    = key_q;
    lim_d    = lim_q;
    hist_d   = hist_q;
    depth_d  = depth_q;
    disc_d   = disc_q;
    hit_d    = hit_q;
    maddr_d  = maddr_q;
    mdepth_d = mdepth_q;
    done_d   = 1'b0;
    rd_en    = 1'b0;
    walk_en  = 1'b0;
    res_en   = 1'b0;
    unique case (state_q)
      WALK_IDLE: begin
        if (start) begin
          walk_en  = 1'b1;
          res_en   = 1'b1;
          key_d    = key;
          lim_d    = (key_len > LEN_MAX) ? LEN_MAX : key_len;
          hist_d   = '0;
          depth_d  = '0;
          disc_d   = DISC_W'(ROOT_DISC);
          hit_d    = 1'b0;
          maddr_d  = '0;
          mdepth_d = '0;
          state_d  = WALK_FETCH;
        end
      end
      WALK_FETCH: begin
        rd_en   = 1'b1;
        state_d = WALK_EVAL;
      end
      WALK_EVAL: begin
        if (node_pfx) begin
          res_en   = 1'b1;
          hit_d    = 1'b1;
          maddr_d  = node_addr;
          mdepth_d = depth_q;
        end
        if ((depth_q == lim_q) || (child_disc == '0)) begin
          done_d  = 1'b1;
          state_d = WALK_IDLE;
        end else begin
          walk_en = 1'b1;
          key_d   = {key_q[KEY_W-2:0], 1'b0};
          hist_d  = {hist_q[KEY_W-2:0], step_bit};
          depth_d = depth_q + LEN_W'(1);
          disc_d  = child_disc;
          state_d = WALK_FETCH;
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WALK_IDLE;
      done_q   <= 1'b0;
      key_q    <= '0;
      lim_q    <= '0;
      hist_q   <= '0;
      depth_q  <= '0;
      disc_q   <= '0;
      hit_q    <= 1'b0;
      maddr_q  <= '0;
      mdepth_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (walk_en) begin
        key_q   <= key_d;
        lim_q   <= lim_d;
        hist_q  <= hist_d;
        depth_q <= depth_d;
        disc_q  <= disc_d;
      end
      if (res_en) begin
        hit_q    <= hit_d;
        maddr_q  <= maddr_d;
        mdepth_q <= mdepth_d;
      end
    end
  end

  assign hist        = hist_q;
  assign depth       = depth_q;
  assign cur_disc    = disc_q;
  assign busy        = (state_q != WALK_IDLE);
  assign done        = done_q;
  assign hit         = hit_q;
  assign match_addr  = maddr_q;
  assign match_depth = mdepth_q;

endmodule

// File: rtl/hx_trie_lookup.sv
module hx_trie_lookup #(
  parameter int KEY_W     = 32,
  parameter int DISC_W    = 2,
  parameter int TBL_DEPTH = 61,
  parameter int ROOT_DISC = 1,
  localparam int LEN_W    = $clog2(KEY_W + 1),
  localparam int ADDR_W   = $clog2(TBL_DEPTH),
  localparam int WORD_W   = 1 + 2 * DISC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [KEY_W-1:0]  key,
  input  logic [LEN_W-1:0]  key_len,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [ADDR_W-1:0] match_addr,
  output logic [LEN_W-1:0]  match_depth
);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [KEY_W-1:0]  hist;
  logic [LEN_W-1:0]  depth;
  logic [DISC_W-1:0] cur_disc;
  logic [ADDR_W-1:0] node_addr;
  logic [WORD_W-1:0] node_word;
  logic              rd_en;
  logic              wr_ok;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  // Host writes only land while the engine is idle
  assign wr_ok = wr_en & ~busy;

  hx_addr_hash #(
    .KEY_W    (KEY_W),
    .LEN_W    (LEN_W),
    .DISC_W   (DISC_W),
    .TBL_DEPTH(TBL_DEPTH),
    .ADDR_W   (ADDR_W)
  ) u_hash (
    .hist (hist),
    .depth(depth),
    .disc (cur_disc),
    .addr (node_addr)
  );

  hx_node_table #(
    .DEPTH (TBL_DEPTH),
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
  ) u_table (
    .clk    (clk),
    .wr_en  (wr_ok),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_addr(node_addr),
    .rd_data(node_word)
  );

  hx_walk_ctrl #(
    .KEY_W    (KEY_W),
    .LEN_W    (LEN_W),
    .DISC_W   (DISC_W),
    .ADDR_W   (ADDR_W),
    .ROOT_DISC(ROOT_DISC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .key        (key),
    .key_len    (key_len),
    .node_word  (node_word),
    .node_addr  (node_addr),
    .hist       (hist),
    .depth      (depth),
    .cur_disc   (cur_disc),
    .rd_en      (rd_en),
    .busy       (busy),
    .done       (done),
    .hit        (hit),
    .match_addr (match_addr),
    .match_depth(match_depth)
  );

endmodule

// File: rtl/hx_trie_lookup_chk.sv
module hx_trie_lookup_chk #(
  parameter int ADDR_W    = 6,
  parameter int LEN_W     = 6,
  parameter int TBL_DEPTH = 61
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              hit,
  input logic [ADDR_W-1:0] match_addr,
  input logic [LEN_W-1:0]  match_depth
);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hit) |-> (match_addr == '0 && match_depth == '0));

  // R5
  match_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(match_addr) < TBL_DEPTH));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(hit) && $stable(match_addr) && $stable(match_depth)));

endmodule

bind hx_trie_lookup hx_trie_lookup_chk #(
  .ADDR_W   (ADDR_W),
  .LEN_W    (LEN_W),
  .TBL_DEPTH(TBL_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .hit        (hit),
  .match_addr (match_addr),
  .match_depth(match_depth)
);

// File: tb/hx_trie_lookup_tb.sv
module hx_trie_lookup_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int KEY_W  = 32;
  localparam int DISC_W = 2;
  localparam int DEPTH  = 61;
  localparam int LEN_W  = 6;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 5;
  localparam int NODES  = 9;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [KEY_W-1:0]  key;
  logic [LEN_W-1:0]  key_len;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic              busy, done, hit;
  logic [ADDR_W-1:0] match_addr;
  logic [LEN_W-1:0]  match_depth;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Trie: root, 0, 1, 00, 01, 11, 010, 011, 0100
  int n_hist [NODES] = '{0, 0, 1, 0, 1, 3, 2, 3, 4};
  int n_len  [NODES] = '{0, 1, 1, 2, 2, 2, 3, 3, 4};
  int n_pfx  [NODES] = '{0, 0, 1, 1, 0, 1, 0, 1, 1};
  int n_disc [NODES];
  int n_addr [NODES];
  int n_word [NODES];
  bit used   [DEPTH];

  hx_trie_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .key_len(key_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .hit(hit),
    .match_addr(match_addr), .match_depth(match_depth)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int bhash(int h, int l, int d);
    longint unsigned v;
    v = (longint'(h) << (LEN_W + DISC_W)) | (longint'(l) << DISC_W) | longint'(d);
    return int'(v % DEPTH);
  endfunction

  function automatic int find_node(int h, int l);
    for (int i = 0; i < NODES; i++)
      if (n_hist[i] == h && n_len[i] == l) return i;
    return -1;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tbl_write(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = WORD_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic build_trie();
    for (int s = 0; s < DEPTH; s++) used[s] = 1'b0;
    n_disc[0] = 1;
    n_addr[0] = bhash(0, 0, 1);
    used[n_addr[0]] = 1'b1;
    for (int i = 1; i < NODES; i++) begin
      bit placed = 1'b0;
      for (int t = 0; t < 3; t++) begin
        int d = ((i + t) % 3) + 1;
        int a = bhash(n_hist[i], n_len[i], d);
        if (!placed && !used[a]) begin
          placed = 1'b1; n_disc[i] = d; n_addr[i] = a; used[a] = 1'b1;
        end
      end
      chk("R3", "bench placement found a free slot", placed, 1);
    end
    for (int i = 0; i < NODES; i++) begin
      int l = find_node(n_hist[i] * 2, n_len[i] + 1);
      int r = find_node(n_hist[i] * 2 + 1, n_len[i] + 1);
      int dl = (l >= 0) ? n_disc[l] : 0;
      int dr = (r >= 0) ? n_disc[r] : 0;
      n_word[i] = (n_pfx[i] << (2 * DISC_W)) | (dl << DISC_W) | dr;
    end
    for (int s = 0; s < DEPTH; s++) tbl_write(s, 0);
    for (int i = 0; i < NODES; i++) tbl_write(n_addr[i], n_word[i]);
  endtask

  // Runs one lookup; optional second start or table write while busy.
  task automatic lookup(input logic [KEY_W-1:0] k, input int len,
                        input bit restart, input bit wr_busy,
                        input int wa, input int wd, output int cycles);
    int cnt = 0;
    @(negedge clk);
    start = 1'b1; key = k; key_len = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    chk("R8", "busy after start", busy, 1);
    while (!done && cnt < 300) begin
      if (cnt == 1 && restart) begin
        start = 1'b1; key = 32'hFFFF_FFFF; key_len = LEN_W'(32);
      end else begin
        start = 1'b0;
      end
      if (cnt == 2 && wr_busy) begin
        wr_en = 1'b1; wr_addr = ADDR_W'(wa); wr_data = WORD_W'(wd);
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0; wr_en = 1'b0;
    cycles = cnt;
    chk("R8", "busy low at done", busy, 0);
  endtask

  task automatic expect_node(string req, int idx);
    chk(req, "hit", hit, 1);
    chk(req, "match_addr", match_addr, n_addr[idx]);
    chk(req, "match_depth", match_depth, n_len[idx]);
  endtask

  task automatic expect_miss(string req);
    chk(req, "hit", hit, 0);
    chk(req, "match_addr", match_addr, 0);
    chk(req, "match_depth", match_depth, 0);
  endtask

  task automatic t_reset();
    start = 0; key = '0; key_len = '0; wr_en = 0; wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "done in reset", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    expect_miss("R1");
  endtask

  task automatic t_leaf_deep();
    int c;
    lookup(32'h4000_0000, 32, 0, 0, 0, 0, c);
    expect_node("R5", 8);
    chk("R8", "cycles for 5 nodes", c, 11);
  endtask

  task automatic t_deepest_of_two();
    int c;
    lookup(32'hC000_0000, 32, 0, 0, 0, 0, c);
    expect_node("R5", 5);
    chk("R4", "cycles path 1-11", c, 7);
    lookup(32'h7000_0000, 32, 0, 0, 0, 0, c);
    expect_node("R4", 7);
    lookup(32'h0000_0000, 32, 0, 0, 0, 0, c);
    expect_node("R3", 3);
  endtask

  task automatic t_missing_child();
    int c;
    lookup(32'hA000_0000, 32, 0, 0, 0, 0, c);
    expect_node("R6", 2);
    chk("R6", "stop at absent left child", c, 5);
    lookup(32'h5000_0000, 32, 0, 0, 0, 0, c);
    expect_miss("R7");
    chk("R6", "stop at absent right child", c, 9);
  endtask

  task automatic t_exhaust();
    int c;
    lookup(32'h4000_0000, 2, 0, 0, 0, 0, c);
    expect_miss("R7");
    chk("R6", "stop at depth equal key_len", c, 7);
    lookup(32'h6000_0000, 3, 0, 0, 0, 0, c);
    expect_node("R6", 7);
    lookup(32'h4000_0000, 0, 0, 0, 0, 0, c);
    expect_miss("R7");
    chk("R6", "root-only walk", c, 3);
  endtask

  task automatic t_root_prefix();
    int c;
    tbl_write(n_addr[0], n_word[0] | (1 << (2 * DISC_W)));
    lookup(32'h4000_0000, 0, 0, 0, 0, 0, c);
    expect_node("R2", 0);
    lookup(32'h5000_0000, 32, 0, 0, 0, 0, c);
    expect_node("R5", 0);
    tbl_write(n_addr[0], n_word[0]);
  endtask

  task automatic t_restart_ignored();
    int c;
    lookup(32'h4000_0000, 32, 1, 0, 0, 0, c);
    expect_node("R9", 8);
    chk("R9", "cycles unchanged by second start", c, 11);
  endtask

  task automatic t_write_blocked();
    int c;
    lookup(32'h4000_0000, 32, 0, 1, n_addr[8], 0, c);
    expect_node("R10", 8);
    lookup(32'h4000_0000, 32, 0, 0, 0, 0, c);
    expect_node("R10", 8);
    tbl_write(n_addr[8], 0);
    lookup(32'h4000_0000, 32, 0, 0, 0, 0, c);
    expect_miss("R10");
    tbl_write(n_addr[8], n_word[8]);
  endtask

  task automatic t_hold();
    int c;
    lookup(32'hC000_0000, 32, 0, 0, 0, 0, c);
    key = 32'h0; key_len = '0;
    repeat (6) @(negedge clk);
    chk("R11", "done stays low", done, 0);
    expect_node("R11", 5);
  endtask

  initial begin
    t_reset();
    build_trie();
    t_leaf_deep();
    t_deepest_of_two();
    t_missing_child();
    t_exhaust();
    t_root_prefix();
    t_restart_ignored();
    t_write_blocked();
    t_hold();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule